// File: doc/BRIEF.md
# Half-Bridge Gate Enable Logic

This block decides, on every clock, whether each switch of a half-bridge power stage may have its gate driven on. It takes a command for the low-side switch and two alternative commands for the high-side switch. One of those is referenced to the low-side ground and the other to the switch node, and only one of the two is wired in a given system. It also takes a mode enable and six fault flags: undervoltage on the auxiliary rail, undervoltage on the bootstrap rail, and an overtemperature flag and an overcurrent flag for each side.

Each command has its own set of blocking conditions. The low-side command and the low-referenced high-side command also share a first-come interlock, so they can never drive both switches at once. An overcurrent event on a switch that is already on latches that switch off until its command falls. All inputs pass through a synchronizer before they are used, and both gate requests leave the block from registers.

Top module: `hb_gate_enable`

## Requirements
- R1: A synchronous active-high reset drives both gate outputs low and clears both overcurrent latches and the interlock ownership. Once reset is released, a command held high turns its gate on again without having to be toggled.
- R2: A change on any input reaches the gate outputs exactly three clock edges after it is first sampled: two synchronizer stages and then the output register.
- R3: `lo_gate_o` is high only when the low-side command is high, `en_i` is high, the auxiliary rail is not in undervoltage, there is no low-side overtemperature, the low-side overcurrent latch is clear, and the interlock is held by the low side.
- R4: The low-referenced high-side command turns its path on only when `en_i` is high, neither rail is in undervoltage, there is no low-side overtemperature, the high-side overcurrent latch is clear, and the interlock is held by the high side. High-side overtemperature does not block this path.
- R5: The switch-node-referenced high-side command is blocked only by bootstrap undervoltage, high-side overtemperature and the high-side overcurrent latch. `en_i`, auxiliary undervoltage and the interlock have no effect on it.
- R6: `hi_gate_o` is the OR of the two gated high-side paths.
- R7: The enable, undervoltage and overtemperature conditions force the affected gate off while its command stays high. They do not latch: the gate comes back once the condition clears.
- R8: The interlock goes to whichever of the low-side command and the low-referenced high-side command is high alone. The other command is then blocked. When the owner falls while the other command is still high, ownership passes to the other side.
- R9: If both interlocked commands become high in the same cycle, neither gate turns on until one of the two commands falls.
- R10: An overcurrent flag sets a side's latch only while that side's gate is on. A set latch keeps the gate off after the flag clears, until the side's command goes low.
- R11: `lo_gate_o` and the low-referenced high-side path are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Mode enable: 1 = active, 0 = standby |
| lo_cmd_i | input | 1 | Low-side switch command |
| hi_cmd_lr_i | input | 1 | High-side command referenced to low-side ground |
| hi_cmd_hr_i | input | 1 | High-side command referenced to the switch node |
| aux_uv_i | input | 1 | Auxiliary rail undervoltage flag |
| bst_uv_i | input | 1 | Bootstrap rail undervoltage flag |
| lo_ot_i | input | 1 | Low-side overtemperature flag |
| hi_ot_i | input | 1 | High-side overtemperature flag |
| lo_oc_i | input | 1 | Low-side overcurrent flag |
| hi_oc_i | input | 1 | High-side overcurrent flag |
| lo_gate_o | output | 1 | Low-side gate-on request |
| hi_gate_o | output | 1 | High-side gate-on request |

## Verification
Wrong interlock ownership shows up three edges after the offending command change: either the second command is let through, or a legal handover is refused. An overcurrent latch that is stuck set keeps a gate dark after the command toggles. A latch that never sets lets the gate come back as soon as the flag drops, within three edges. A blocking term that is missing from one input's set shows only in the exhaustive sweep, which compares both gates against an independent model for every combination of faults and commands.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LO   = 2'd1,
    OWN_HI   = 2'd2
  } owner_e;

  typedef struct packed {
    logic en;
    logic aux_uv;
    logic bst_uv;
    logic lo_ot;
    logic hi_ot;
    logic lo_oc;
    logic hi_oc;
    logic lo_cmd;
    logic hlr_cmd;
    logic hhr_cmd;
  } hbg_in_t;

  // first-come ownership over the two ground-referenced commands
  function automatic owner_e owner_next(owner_e cur, logic lo, logic hi);
    owner_e nx;
    case (cur)
      OWN_LO:  nx = lo ? OWN_LO : (hi ? OWN_HI : OWN_NONE);
      OWN_HI:  nx = hi ? OWN_HI : (lo ? OWN_LO : OWN_NONE);
      default: nx = (lo && !hi) ? OWN_LO : ((hi && !lo) ? OWN_HI : OWN_NONE);
    endcase
    return nx;
  endfunction

  function automatic logic lo_permit(hbg_in_t s, owner_e own, logic blk);
    return s.lo_cmd && s.en && !s.aux_uv && !s.lo_ot && !blk && (own == OWN_LO);
  endfunction

  function automatic logic hlr_permit(hbg_in_t s, owner_e own, logic blk);
    return s.hlr_cmd && s.en && !s.aux_uv && !s.bst_uv && !s.lo_ot && !blk
           && (own == OWN_HI);
  endfunction

  function automatic logic hhr_permit(hbg_in_t s, logic blk);
    return s.hhr_cmd && !s.bst_uv && !s.hi_ot && !blk;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (STAGES <= 1) begin : g_single
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= d;
    end
    assign q = r;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= {r[STAGES-2:0], d};
    end
    assign q = r[STAGES-1];
  end
endmodule

// File: rtl/hbg_interlock.sv
module hbg_interlock
  import hbg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   lo_cmd,
  input  logic   hi_cmd,
  output owner_e own_next,
  output owner_e own_q
);
  assign own_next = owner_next(own_q, lo_cmd, hi_cmd);

  always_ff @(posedge clk) begin
    if (rst) own_q <= OWN_NONE;
    else     own_q <= own_next;
  end
endmodule

// File: rtl/hbg_oc_latch.sv
module hbg_oc_latch (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic oc,
  input  logic gate_q,
  output logic blk,
  output logic latch_q
);
  // an event counts only while the switch is already on
  assign blk = latch_q || (oc && gate_q);

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= cmd && blk;
  end
endmodule

// File: rtl/hb_gate_enable.sv
module hb_gate_enable
  import hbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic lo_cmd_i,
  input  logic hi_cmd_lr_i,
  input  logic hi_cmd_hr_i,
  input  logic aux_uv_i,
  input  logic bst_uv_i,
  input  logic lo_ot_i,
  input  logic hi_ot_i,
  input  logic lo_oc_i,
  input  logic hi_oc_i,
  output logic lo_gate_o,
  output logic hi_gate_o
);
  localparam int IN_W = $bits(hbg_in_t);

  hbg_in_t raw, syn;
  owner_e  own_d, own_q;
  logic    lo_blk, hi_blk, lo_latch, hi_latch;
  logic    lo_on_d, hlr_on_d, hhr_on_d;
  logic    lo_q, hlr_q, hhr_q;
  logic    hi_cmd_any;

  assign raw = '{en: en_i, aux_uv: aux_uv_i, bst_uv: bst_uv_i, lo_ot: lo_ot_i,
                 hi_ot: hi_ot_i, lo_oc: lo_oc_i, hi_oc: hi_oc_i,
                 lo_cmd: lo_cmd_i, hlr_cmd: hi_cmd_lr_i, hhr_cmd: hi_cmd_hr_i};

  hbg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  hbg_interlock u_ilk (
    .clk(clk), .rst(rst), .lo_cmd(syn.lo_cmd), .hi_cmd(syn.hlr_cmd),
    .own_next(own_d), .own_q(own_q)
  );

  assign hi_cmd_any = syn.hlr_cmd || syn.hhr_cmd;

  hbg_oc_latch u_lo_oc (
    .clk(clk), .rst(rst), .cmd(syn.lo_cmd), .oc(syn.lo_oc), .gate_q(lo_q),
    .blk(lo_blk), .latch_q(lo_latch)
  );

  hbg_oc_latch u_hi_oc (
    .clk(clk), .rst(rst), .cmd(hi_cmd_any), .oc(syn.hi_oc), .gate_q(hi_gate_o),
    .blk(hi_blk), .latch_q(hi_latch)
  );

  always_comb begin
    lo_on_d  = lo_permit(syn, own_d, lo_blk);
    hlr_on_d = hlr_permit(syn, own_d, hi_blk);
    hhr_on_d = hhr_permit(syn, hi_blk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= 1'b0;
      hlr_q <= 1'b0;
      hhr_q <= 1'b0;
    end else begin
      lo_q  <= lo_on_d;
      hlr_q <= hlr_on_d;
      hhr_q <= hhr_on_d;
    end
  end

  assign lo_gate_o = lo_q;
  assign hi_gate_o = hlr_q || hhr_q;
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk (
  input logic clk,
  input logic rst,
  input logic lo_gate,
  input logic hi_gate,
  input logic hlr_gate,
  input logic hhr_gate,
  input logic s_en,
  input logic s_aux_uv,
  input logic s_bst_uv,
  input logic s_lo_ot,
  input logic s_hi_ot,
  input logic s_lo_cmd,
  input logic lo_latch,
  input logic hi_latch
);
  // R1
  reset_off_chk: assert property (@(posedge clk) rst |=> (!lo_gate && !hi_gate));

  // R11
  no_cross_chk: assert property (@(posedge clk) disable iff (rst) !(lo_gate && hlr_gate));

  // R3
  lo_fault_chk: assert property (@(posedge clk) disable iff (rst)
    lo_gate |-> $past(s_en && !s_aux_uv && !s_lo_ot && s_lo_cmd));

  // R5
  hhr_fault_chk: assert property (@(posedge clk) disable iff (rst)
    hhr_gate |-> $past(!s_bst_uv && !s_hi_ot));

  // R4
  hlr_fault_chk: assert property (@(posedge clk) disable iff (rst)
    hlr_gate |-> $past(s_en && !s_aux_uv && !s_bst_uv && !s_lo_ot));

  // R10
  lo_latch_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_latch) |-> $past(lo_gate));

  // R10
  hi_latch_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_latch) |-> $past(hi_gate));

  // R10
  lo_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lo_latch |-> !lo_gate);
endmodule

bind hb_gate_enable hbg_chk u_chk (
  .clk(clk), .rst(rst), .lo_gate(lo_gate_o), .hi_gate(hi_gate_o),
  .hlr_gate(hlr_q), .hhr_gate(hhr_q),
  .s_en(syn.en), .s_aux_uv(syn.aux_uv), .s_bst_uv(syn.bst_uv),
  .s_lo_ot(syn.lo_ot), .s_hi_ot(syn.hi_ot), .s_lo_cmd(syn.lo_cmd),
  .lo_latch(lo_latch), .hi_latch(hi_latch)
);

// File: tb/sim_hb_gate_enable.sv
module sim_hb_gate_enable;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, lo = 0, hl = 0, hh = 0, aux = 0, bst = 0, lot = 0, hot = 0, loc = 0, hoc = 0;
  logic lo_g, hi_g;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  hb_gate_enable u0 (
    .clk(clk), .rst(rst), .en_i(en), .lo_cmd_i(lo), .hi_cmd_lr_i(hl),
    .hi_cmd_hr_i(hh), .aux_uv_i(aux), .bst_uv_i(bst), .lo_ot_i(lot),
    .hi_ot_i(hot), .lo_oc_i(loc), .hi_oc_i(hoc),
    .lo_gate_o(lo_g), .hi_gate_o(hi_g)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cmds(logic l, logic a, logic b);
    lo = l; hl = a; hh = b;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset lo", lo_g, 1'b0);
    chk("R1 reset hi", hi_g, 1'b0);
    rst = 1'b0;
    settle();

    // R2 latency: gate on at the third edge, not before
    en = 1; lo = 1;
    repeat (2) @(negedge clk);
    chk("R2 early", lo_g, 1'b0);
    @(negedge clk);
    chk("R2 on time", lo_g, 1'b1);
    cmds(0, 0, 0); settle();

    // exhaustive sweep of faults x commands, starting from no owner
    for (int f = 0; f < 32; f++) begin
      for (int c = 0; c < 8; c++) begin
        logic elo, ehl, ehh;
        en = f[0]; aux = f[1]; bst = f[2]; lot = f[3]; hot = f[4];
        cmds(c[0], c[1], c[2]);
        settle();
        elo = c[0] & ~c[1] & f[0] & ~f[1] & ~f[3];
        ehl = c[1] & ~c[0] & f[0] & ~f[1] & ~f[2] & ~f[3];
        ehh = c[2] & ~f[2] & ~f[4];
        chk("R3 sweep lo", lo_g, elo);
        chk("R4/R5/R6 sweep hi", hi_g, ehl | ehh);
        if (c[2] == 0) chk("R11 sweep", lo_g & hi_g, 1'b0);
        cmds(0, 0, 0); settle();
      end
    end
    en = 1; aux = 0; bst = 0; lot = 0; hot = 0; settle();

    // R7 forcing off without latching
    lo = 1; settle();
    lot = 1; settle(); chk("R7 lo ot forces off", lo_g, 1'b0);
    lot = 0; settle(); chk("R7 lo returns", lo_g, 1'b1);
    en = 0; settle(); chk("R7 standby forces off", lo_g, 1'b0);
    en = 1; settle(); chk("R7 enable returns", lo_g, 1'b1);
    cmds(0, 0, 1); settle(); chk("R5 hr on", hi_g, 1'b1);
    hot = 1; settle(); chk("R7 hi ot forces hr off", hi_g, 1'b0);
    hot = 0; en = 0; aux = 1; settle(); chk("R5 hr ignores en/aux", hi_g, 1'b1);
    en = 1; aux = 0; cmds(0, 0, 0); settle();

    // R8 first-come ownership and handover
    cmds(1, 0, 0); settle();
    hl = 1; settle();
    chk("R8 hi blocked", hi_g, 1'b0);
    chk("R8 lo keeps", lo_g, 1'b1);
    lo = 0; settle();
    chk("R8 handover hi", hi_g, 1'b1);
    chk("R8 handover lo off", lo_g, 1'b0);
    lo = 1; settle();
    chk("R8 lo blocked", lo_g, 1'b0);
    cmds(0, 0, 0); settle();

    // R9 simultaneous rise
    cmds(1, 1, 0); settle();
    chk("R9 tie lo", lo_g, 1'b0);
    chk("R9 tie hi", hi_g, 1'b0);
    hl = 0; settle();
    chk("R9 lo after release", lo_g, 1'b1);
    cmds(0, 0, 0); settle();

    // R10 overcurrent latch
    loc = 1; settle(); loc = 0; lo = 1; settle();
    chk("R10 oc while off ignored", lo_g, 1'b1);
    loc = 1; settle(); chk("R10 lo oc off", lo_g, 1'b0);
    loc = 0; settle(); chk("R10 lo latched", lo_g, 1'b0);
    lo = 0; settle(); lo = 1; settle();
    chk("R10 lo cleared by cmd low", lo_g, 1'b1);
    cmds(0, 0, 1); settle();
    hoc = 1; settle(); chk("R10 hi oc off", hi_g, 1'b0);
    hoc = 0; settle(); chk("R10 hi latched", hi_g, 1'b0);
    hh = 0; settle(); hh = 1; settle();
    chk("R10 hi cleared by cmd low", hi_g, 1'b1);
    cmds(0, 0, 0); settle();

    // R1 reset clears a set latch
    lo = 1; settle(); loc = 1; settle(); loc = 0; settle();
    chk("R1 pre-reset latched", lo_g, 1'b0);
    rst = 1; @(negedge clk);
    chk("R1 reset gate off", lo_g, 1'b0);
    rst = 0; settle();
    chk("R1 latch cleared", lo_g, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule